// File: doc/BRIEF.md
# Audio Control Register Slave (I2C, write-only)

This block is the control port of a three-band stereo audio processor. It watches an I2C bus through its system clock, recognises start and stop conditions, and accepts write transfers addressed to its fixed chip address. The first byte after the address selects one of eight control registers and chooses whether later bytes stay on that register or step through the register set. Every data byte that lands on a valid register updates it and raises a one-cycle write pulse with the register index, so downstream analog-control logic can react.

The block drives SDA only as an open-drain pull-down (`sda_oe` high means pull low), and only while acknowledging. It never answers reads, never stretches the clock, and on a foreign address stays silent until the next start. All eight registers are exposed as one flat vector and come out of reset at fixed non-zero codes.

Top module: `audio_ctrl_i2c_regs`

## Requirements
- R1: A start is SDA falling while SCL is high; a stop is SDA rising while SCL is high. After a stop, SCL clocks without a new start write no register and never assert `sda_oe`.
- R2: Bytes are 8 bits, MSB first; for each byte of an addressed transfer the slave pulls SDA low (`sda_oe`=1) across the ninth SCL clock, so SDA reads 0 while SCL is high on that clock.
- R3: Only the address byte 0x88 is accepted. Any other address byte (including 0x89) gets no acknowledge (SDA reads 1 on its ninth clock), and the rest of that transfer writes nothing and never asserts `sda_oe`.
- R4: In the byte after the address, bits [3:0] are the register index, bit 4 is the increment flag, and bits [7:5] have no effect.
- R5: With the increment flag 0, every data byte of the transfer is written to the same register; the last one remains.
- R6: With the increment flag 1, the first data byte goes to the sent index and each later byte to the next index; bytes aimed at indices 8 to 15 are dropped (no write, no pulse), including when the sent index is already 8 to 15. Dropped bytes are still acknowledged.
- R7: After reset the register bytes are: index 0 = 0x02, 1 = 0x0E, 2 = 0x70, 3 = 0x07, 4 = 0x0E, 5 = 0x0E, 6 = 0x78, 7 = 0x78; `sda_oe` and `wr_strobe` are 0.
- R8: A start in the middle of a transfer restarts decoding at the address byte; register contents already written are kept.
- R9: Each register write raises `wr_strobe` for exactly one clock with `wr_index` giving the index, in the same cycle that the new value appears on `ctrl_regs`; no register changes while `wr_strobe` is low.
- R10: Register i occupies `ctrl_regs[8*i+7:8*i]`; index 0 input select, 1 input gain, 2 volume, 3 bass, 4 mid, 5 treble, 6 right speaker attenuation, 7 left speaker attenuation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low (acknowledge) |
| ctrl_regs | output | 64 | Eight control registers, index i in bits [8i+7:8i] |
| wr_strobe | output | 1 | One-cycle pulse on each register write |
| wr_index | output | 3 | Index of the register written with the pulse |

## Verification
A register value and its write pulse appear three system clocks after the SCL rising edge that carries the last bit of the data byte (two synchronizer flops and one decode register), and the acknowledge pull-down starts three clocks after the SCL falling edge that closes the eighth bit and ends three clocks after the ninth falling edge. The bench holds every SCL phase for ten clocks, samples the acknowledge in the middle of the ninth high phase, and compares registers only after the stop, long after any write can still be in flight. Write pulses and pull-down cycles are counted by a monitor on the falling clock edge, so their counts and the value seen with each pulse are taken half a cycle away from the edge that drives them.

// File: rtl/acr_pkg.sv
// Package: shared sizes, bus state encoding and reset codes for the
// audio control register slave. Assumes eight byte-wide registers.
package acr_pkg;
    localparam int          NUM_REGS  = 8;
    localparam int          DATA_W    = 8;
    localparam int          IDX_W     = $clog2(NUM_REGS);
    localparam int          PTR_W     = IDX_W + 1;
    localparam int          FLAT_W    = NUM_REGS * DATA_W;
    localparam logic [7:0]  CHIP_ADDR = 8'h88;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_DATA,
        ST_SKIP
    } bus_state_t;

    // Reset code for each register index.
    function automatic logic [DATA_W-1:0] reset_code(input int idx);
        case (idx)
            0:       return 8'h02;  // input select: second input
            1:       return 8'h0E;  // input gain: 28 dB
            2:       return 8'h70;  // volume: mute
            3:       return 8'h07;  // bass: flat
            4:       return 8'h0E;  // mid: +2 dB
            5:       return 8'h0E;  // treble: +2 dB
            default: return 8'h78;  // speaker attenuators: mute
        endcase
    endfunction
endpackage

// File: rtl/acr_bus_sync.sv
// Bus sampler: brings SCL and SDA into the clock domain through
// SYNC_DEPTH flops plus one history flop, and flags SCL edges and
// start/stop conditions. Assumes the bus is slower than clk/8.
module acr_bus_sync #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_DEPTH:0] scl_pipe;
    logic [SYNC_DEPTH:0] sda_pipe;
    logic                scl_now, scl_old, sda_old;

    // Shift both lines through the synchronizer and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_DEPTH-1:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC_DEPTH-1:0], sda_in};
        end
    end

    // Decode edges and bus conditions from the last two stages.
    always_comb begin
        scl_now   = scl_pipe[SYNC_DEPTH-1];
        scl_old   = scl_pipe[SYNC_DEPTH];
        sda_s     = sda_pipe[SYNC_DEPTH-1];
        sda_old   = sda_pipe[SYNC_DEPTH];
        scl_rise  = scl_now & ~scl_old;
        scl_fall  = ~scl_now & scl_old;
        start_det = scl_now & scl_old & sda_old & ~sda_s;
        stop_det  = scl_now & scl_old & ~sda_old & sda_s;
    end
endmodule

// File: rtl/acr_byte_rx.sv
// Byte receiver and transfer decoder: counts bits, matches the chip
// address, captures the register pointer and increment flag, drives the
// acknowledge and issues write requests. Assumes synchronized inputs.
module acr_byte_rx
    import acr_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR = CHIP_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe,
    output logic              wr_req,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);
    bus_state_t        state;
    logic [3:0]        bit_cnt;
    logic [DATA_W-2:0] shreg;
    logic [PTR_W-1:0]  ptr;
    logic              inc_en;
    logic              ack_pend;
    logic              last_bit;
    logic [DATA_W-1:0] byte_now;

    // Byte assembled on the eighth rising edge and the write request.
    always_comb begin
        byte_now = {shreg, sda_s};
        last_bit = scl_rise && (bit_cnt == 4'd7);
        wr_req   = last_bit && (state == ST_DATA) && !ptr[PTR_W-1];
        wr_idx   = ptr[IDX_W-1:0];
        wr_data  = byte_now;
    end

    // Transfer state, bit counter, pointer and acknowledge drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            ptr      <= '0;
            inc_en   <= 1'b0;
            ack_pend <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (start_det) begin
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            ack_pend <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (stop_det) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            ack_pend <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            if (scl_rise && state != ST_IDLE) begin
                if (bit_cnt == 4'd8) begin
                    bit_cnt <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 4'd1;
                    shreg   <= {shreg[DATA_W-3:0], sda_s};
                end
            end
            if (last_bit) begin
                case (state)
                    ST_ADDR: begin
                        if (byte_now == DEV_ADDR) begin
                            state    <= ST_SUB;
                            ack_pend <= 1'b1;
                        end else begin
                            state    <= ST_SKIP;
                            ack_pend <= 1'b0;
                        end
                    end
                    ST_SUB: begin
                        ptr      <= byte_now[PTR_W-1:0];
                        inc_en   <= byte_now[4];
                        ack_pend <= 1'b1;
                        state    <= ST_DATA;
                    end
                    ST_DATA: begin
                        ack_pend <= 1'b1;
                        if (inc_en && !ptr[PTR_W-1])
                            ptr <= ptr + 1'b1;
                    end
                    default: ack_pend <= 1'b0;
                endcase
            end
            if (scl_fall) begin
                if (bit_cnt == 4'd8 && ack_pend) begin
                    sda_oe   <= 1'b1;
                    ack_pend <= 1'b0;
                end else if (bit_cnt == 4'd0) begin
                    sda_oe   <= 1'b0;
                end
            end
        end
    end

    AST_BITCNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8);  // R2
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP || state == ST_IDLE) |-> !sda_oe);  // R3
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) && !$past(start_det) |-> (state == ST_IDLE && !sda_oe));  // R1
    AST_START_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_det) |-> (state == ST_ADDR && bit_cnt == 4'd0));  // R8
endmodule

// File: rtl/acr_reg_file.sv
// Control register bank: eight bytes with fixed reset codes, one write
// port, and a registered write pulse aligned with the updated value.
module acr_reg_file
    import acr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [FLAT_W-1:0] regs_flat,
    output logic              wr_strobe,
    output logic [IDX_W-1:0]  wr_index
);
    // Update the addressed register, or load reset codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++)
                regs_flat[i*DATA_W +: DATA_W] <= reset_code(i);
        end else if (wr_en) begin
            regs_flat[wr_idx*DATA_W +: DATA_W] <= wr_data;
        end
    end

    // Register the write pulse and index alongside the data update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_strobe <= 1'b0;
            wr_index  <= '0;
        end else begin
            wr_strobe <= wr_en;
            if (wr_en)
                wr_index <= wr_idx;
        end
    end

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);  // R9
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strobe && $past(rst_n) |-> $stable(regs_flat));  // R9
endmodule

// File: rtl/audio_ctrl_i2c_regs.sv
// Top: write-only I2C slave holding the eight audio control registers.
// Assumes an open-drain pad outside, with sda_oe = 1 pulling SDA low.
module audio_ctrl_i2c_regs
    import acr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [FLAT_W-1:0] ctrl_regs,
    output logic              wr_strobe,
    output logic [IDX_W-1:0]  wr_index
);
    logic              scl_rise, scl_fall, sda_s, start_det, stop_det;
    logic              wr_req;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;

    acr_bus_sync #(.SYNC_DEPTH(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    acr_byte_rx #(.DEV_ADDR(CHIP_ADDR)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe),
        .wr_req    (wr_req),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    acr_reg_file u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_req),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .regs_flat (ctrl_regs),
        .wr_strobe (wr_strobe),
        .wr_index  (wr_index)
    );
endmodule

// File: tb/sim_audio_ctrl_i2c_regs.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_audio_ctrl_i2c_regs;
    localparam int Q = 10;  // clocks per quarter SCL period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_drv = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [63:0] ctrl_regs;
    logic        wr_strobe;
    logic [2:0]  wr_index;

    int checks = 0;
    int errors = 0;
    int strobe_cnt = 0;
    int oe_cycles = 0;
    logic [2:0] last_idx = '0;
    logic [7:0] last_val = '0;
    logic [7:0] exp_r [8];
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    assign sda_line = sda_drv & ~sda_oe;

    audio_ctrl_i2c_regs u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .ctrl_regs (ctrl_regs),
        .wr_strobe (wr_strobe),
        .wr_index  (wr_index)
    );

    // Port monitor away from the active edge.
    always @(negedge clk) begin
        if (rst_n && wr_strobe) begin
            strobe_cnt = strobe_cnt + 1;
            last_idx   = wr_index;
            last_val   = ctrl_regs[wr_index*8 +: 8];
        end
        if (rst_n && sda_oe) oe_cycles = oe_cycles + 1;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic waitq(input int n);
        repeat (n * Q) @(posedge clk);
    endtask

    task automatic bus_start;
        sda_drv = 1'b1; waitq(1);
        scl = 1'b1;     waitq(1);
        sda_drv = 1'b0; waitq(1);
        scl = 1'b0;     waitq(1);
    endtask

    task automatic bus_stop;
        sda_drv = 1'b0; waitq(1);
        scl = 1'b1;     waitq(1);
        sda_drv = 1'b1; waitq(2);
    endtask

    task automatic put_bit(input logic b);
        sda_drv = b;  waitq(1);
        scl = 1'b1;   waitq(2);
        scl = 1'b0;   waitq(1);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int k = 7; k >= 0; k--) put_bit(b[k]);
        sda_drv = 1'b1; waitq(1);
        scl = 1'b1;     waitq(1);
        @(negedge clk); ack = sda_line;
        waitq(1);
        scl = 1'b0;     waitq(1);
    endtask

    task automatic chk_regs(input string req);
        for (int i = 0; i < 8; i++)
            chk(req, $sformatf("reg %0d", i), {24'd0, ctrl_regs[i*8 +: 8]}, {24'd0, exp_r[i]});
    endtask

    task automatic t_reset;
        exp_r = '{8'h02, 8'h0E, 8'h70, 8'h07, 8'h0E, 8'h0E, 8'h78, 8'h78};
        @(negedge clk);
        chk_regs("R7 R10 reset");
        chk("R7", "sda_oe after reset", {31'd0, sda_oe}, 0);
        chk("R7", "wr_strobe after reset", {31'd0, wr_strobe}, 0);
    endtask

    task automatic t_single;
        logic a0, a1, a2;
        int s0 = strobe_cnt;
        bus_start;
        send_byte(8'h88, a0); send_byte(8'h02, a1); send_byte(8'h15, a2);
        bus_stop;
        exp_r[2] = 8'h15;
        chk("R2", "ack on address", {31'd0, a0}, 0);
        chk("R2", "ack on sub/data", {30'd0, a1, a2}, 0);
        chk("R9", "one strobe", strobe_cnt - s0, 1);
        chk("R9", "strobe index", {29'd0, last_idx}, 2);
        chk("R9", "value with strobe", {24'd0, last_val}, 32'h15);
        chk_regs("R10 single write");
    endtask

    task automatic t_same;
        logic a;
        int s0 = strobe_cnt;
        bus_start;
        send_byte(8'h88, a); send_byte(8'h05, a);
        send_byte(8'h03, a); send_byte(8'h09, a); send_byte(8'h0C, a);
        bus_stop;
        exp_r[5] = 8'h0C;
        chk("R5", "strobes without increment", strobe_cnt - s0, 3);
        chk("R5", "index held", {29'd0, last_idx}, 5);
        chk_regs("R5 same register");
    endtask

    task automatic t_incr;
        logic a, ad;
        int s0 = strobe_cnt;
        bus_start;
        send_byte(8'h88, a); send_byte(8'h16, a);
        send_byte(8'h11, a); send_byte(8'h22, a);
        send_byte(8'h33, ad); send_byte(8'h44, a);
        bus_stop;
        exp_r[6] = 8'h11; exp_r[7] = 8'h22;
        chk("R6", "strobes stop at index 7", strobe_cnt - s0, 2);
        chk("R6", "last index", {29'd0, last_idx}, 7);
        chk("R6", "dropped byte acked", {31'd0, ad}, 0);
        chk_regs("R6 increment");
    endtask

    task automatic t_high;
        logic a;
        int s0 = strobe_cnt;
        bus_start;
        send_byte(8'h88, a); send_byte(8'h19, a);
        send_byte(8'h55, a); send_byte(8'h66, a);
        bus_stop;
        chk("R6", "no strobe for index 9", strobe_cnt - s0, 0);
        chk_regs("R6 high index dropped");
    endtask

    task automatic t_dontcare;
        logic a;
        int s0 = strobe_cnt;
        bus_start;
        send_byte(8'h88, a); send_byte(8'hE4, a);
        send_byte(8'h2A, a); send_byte(8'h2B, a);
        bus_stop;
        exp_r[4] = 8'h2B;
        chk("R4", "upper bits ignored, no increment", {29'd0, last_idx}, 4);
        chk("R4", "two strobes", strobe_cnt - s0, 2);
        bus_start;
        send_byte(8'h88, a); send_byte(8'hF0, a);
        send_byte(8'h01, a); send_byte(8'h03, a);
        bus_stop;
        exp_r[0] = 8'h01; exp_r[1] = 8'h03;
        chk_regs("R4 sub-address fields");
    endtask

    task automatic t_badaddr(input logic [7:0] adr);
        logic a0, a;
        int s0 = strobe_cnt;
        int o0;
        bus_start;
        o0 = oe_cycles;
        send_byte(adr, a0); send_byte(8'h02, a); send_byte(8'h7F, a);
        bus_stop;
        chk("R3", $sformatf("no ack for %0h", adr), {31'd0, a0}, 1);
        chk("R3", "no pull-down in foreign transfer", oe_cycles - o0, 0);
        chk("R3", "no strobe", strobe_cnt - s0, 0);
        chk_regs("R3 foreign address");
    endtask

    task automatic t_after_stop;
        int s0 = strobe_cnt;
        int o0 = oe_cycles;
        logic [26:0] pat = 27'h4_44_02_3C;
        for (int k = 26; k >= 0; k--) put_bit(pat[k]);
        sda_drv = 1'b1;
        scl = 1'b1;
        waitq(2);
        chk("R1", "no strobe without start", strobe_cnt - s0, 0);
        chk("R1", "no pull-down without start", oe_cycles - o0, 0);
        chk_regs("R1 idle after stop");
    endtask

    task automatic t_restart;
        logic a;
        bus_start;
        send_byte(8'h88, a); send_byte(8'h01, a); send_byte(8'h05, a);
        bus_start;
        send_byte(8'h88, a);
        chk("R8", "ack after repeated start", {31'd0, a}, 0);
        send_byte(8'h03, a); send_byte(8'h0A, a);
        bus_start;
        send_byte(8'h88, a); send_byte(8'h07, a);
        bus_start;
        send_byte(8'h88, a); send_byte(8'h00, a); send_byte(8'h01, a);
        bus_stop;
        exp_r[1] = 8'h05; exp_r[3] = 8'h0A; exp_r[0] = 8'h01;
        chk_regs("R8 repeated start");
    endtask

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        t_reset;
        t_single;
        t_same;
        t_incr;
        t_high;
        t_dontcare;
        t_badaddr(8'h90);
        t_badaddr(8'h89);
        t_after_stop;
        t_restart;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule